// File: doc/BRIEF.md
# Base-Index Effective Address Generator

This block forms the operand address of a memory-reference instruction from its decoded fields: a destination select, an index select, a base select and a 16-bit displacement. It keeps eight 32-bit base registers and reads a flattened copy of the eight 32-bit arithmetic/index registers. The address is the named base register plus the zero-extended displacement plus, when the index select is non-zero, the named index register. The sum wraps modulo 2^32.

A zero base select on an ordinary operand instruction means there is no memory operand. The index select then names a source register, and the block reports register mode. Jumps that name an index register do not jump to the computed address. They read a 32-bit word from that address over a valid/ready read port and jump to the word they read. A load-base-with-address instruction writes the computed address into the base register named by the destination select and makes no memory access. A separate write port loads the base registers with values computed elsewhere.

Top module: `oa_operand_addr`

## Requirements
- R1: After reset, req_ready_o is 1 and res_valid_o, tgt_valid_o and rd_valid_o are 0.
- R2: A request is accepted on a clock edge where req_valid_i and req_ready_o are both 1. For an operand instruction (op_i 0, or 3, which is handled the same way) with base_sel_i non-zero, the next cycle shows res_valid_o=1, use_mem_o=1 and ea_o = base[base_sel_i] + {16'b0, disp_i} + index term, computed modulo 2^32. The displacement is zero-extended.
- R3: When idx_sel_i is 0, the index term is 0 whatever xreg_i holds for register 0. Otherwise it is xreg_i[idx_sel_i*32 +: 32].
- R4: An operand instruction with base_sel_i 0 gives res_valid_o=1, use_mem_o=0, src_reg_o=idx_sel_i and ea_o=0.
- R5: When base_we_i is 1, base_wdata_i is written into base register base_wsel_i at the clock edge. A write to base register 0 has no effect, and base register 0 always adds 0 to an address.
- R6: A load-base-with-address instruction (op_i 2) shows its address on ea_o with res_valid_o=1 and use_mem_o=0 in the next cycle, writes that address into base register dst_sel_i, and raises no read request. If base_we_i writes in the same cycle, this write takes priority.
- R7: A jump (op_i 1) with idx_sel_i 0 shows tgt_valid_o=1 and tgt_o equal to the computed address in the next cycle, with no read request and res_valid_o=0.
- R8: A jump with idx_sel_i non-zero holds rd_valid_o=1 and rd_addr_o equal to the computed address, from the cycle after acceptance until rd_ready_i is seen. req_ready_o stays 0 until the target is delivered, and requests made in that time are ignored.
- R9: After the read handshake, the first cycle with rd_data_valid_i=1 captures rd_data_i. In the next cycle tgt_valid_o=1 and tgt_o equals that word. tgt_valid_o lasts one cycle.
- R10: res_valid_o and tgt_valid_o each last one cycle and are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Decoded instruction present |
| req_ready_o | output | 1 | Block can accept an instruction |
| op_i | input | 2 | 0 operand, 1 jump, 2 load base with address, 3 treated as operand |
| dst_sel_i | input | 3 | Destination register select |
| idx_sel_i | input | 3 | Index select, or source register in register mode |
| base_sel_i | input | 3 | Base register select |
| disp_i | input | 16 | Unsigned displacement |
| xreg_i | input | 256 | Arithmetic/index registers, register k at bits k*32 +: 32 |
| base_we_i | input | 1 | Base register write enable |
| base_wsel_i | input | 3 | Base register write select |
| base_wdata_i | input | 32 | Base register write data |
| res_valid_o | output | 1 | Operand or load-base result valid |
| ea_o | output | 32 | Effective address |
| use_mem_o | output | 1 | Second operand comes from memory |
| src_reg_o | output | 3 | Source register in register mode |
| rd_valid_o | output | 1 | Indirect target read request |
| rd_ready_i | input | 1 | Read request accepted |
| rd_addr_o | output | 32 | Indirect read address |
| rd_data_valid_i | input | 1 | Read data returned |
| rd_data_i | input | 32 | Read data |
| tgt_valid_o | output | 1 | Jump target valid |
| tgt_o | output | 32 | Jump target |

## Verification
The hardest state to reach is the middle of an indexed jump. The read request must be stalled, new requests are arriving and must be dropped, and the data has not yet returned. The stimulus gets there with a memory responder in the bench that holds rd_ready_i low for several cycles and drives a fresh request during the stall. It then checks that the request stays stable, that no result appears and that req_ready_o stays low. Only after that does it complete the handshake and return the data, and it checks that the target appears exactly one cycle later.

// File: rtl/oa_pkg.sv
package oa_pkg;
  typedef enum logic [1:0] {
    OP_OPND = 2'd0,
    OP_JUMP = 2'd1,
    OP_LBA  = 2'd2,
    OP_ALT  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_WAIT = 2'd2
  } fstate_e;
endpackage

// File: rtl/oa_base_rf.sv
module oa_base_rf #(
  parameter int NREG = 8,
  parameter int AW   = 32,
  localparam int SW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [SW-1:0] wsel_i,
  input  logic [AW-1:0] wdata_i,
  input  logic [SW-1:0] rsel_i,
  output logic [AW-1:0] rdata_o
);
  logic [AW-1:0] regs_q [NREG];

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    if (k == 0) begin : g_zero
      // entry zero selects register mode, so it never carries an address
      assign regs_q[k] = '0;
    end else begin : g_ff
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                              regs_q[k] <= '0;
        else if (we_i && wsel_i == SW'(k))        regs_q[k] <= wdata_i;
      end
    end
  end

  assign rdata_o = regs_q[rsel_i];

  assert_base_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wsel_i != '0) |=> regs_q[$past(wsel_i)] == $past(wdata_i));
endmodule

// File: rtl/oa_addr_calc.sv
module oa_addr_calc #(
  parameter int NREG = 8,
  parameter int AW   = 32,
  parameter int DW   = 16,
  localparam int SW  = $clog2(NREG)
) (
  input  logic [AW-1:0]      base_val_i,
  input  logic [NREG*AW-1:0] xreg_i,
  input  logic [SW-1:0]      idx_sel_i,
  input  logic [DW-1:0]      disp_i,
  output logic [AW-1:0]      ea_o
);
  logic [AW-1:0] idx_term;

  always_comb begin
    idx_term = '0;
    if (idx_sel_i != '0) idx_term = xreg_i[idx_sel_i*AW +: AW];
    ea_o = base_val_i + {{(AW-DW){1'b0}}, disp_i} + idx_term;
  end
endmodule

// File: rtl/oa_indirect_fetch.sv
module oa_indirect_fetch
  import oa_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          indirect_i,
  input  logic [AW-1:0] ea_i,
  output logic          busy_o,
  output logic          rd_valid_o,
  input  logic          rd_ready_i,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_data_valid_i,
  input  logic [AW-1:0] rd_data_i,
  output logic          tgt_valid_o,
  output logic [AW-1:0] tgt_o
);
  fstate_e       state_q;
  logic [AW-1:0] addr_q, tgt_q;
  logic          tgt_v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FS_IDLE;
      addr_q  <= '0;
      tgt_q   <= '0;
      tgt_v_q <= 1'b0;
    end else begin
      tgt_v_q <= 1'b0;
      unique case (state_q)
        FS_IDLE: if (start_i) begin
          if (indirect_i) begin
            addr_q  <= ea_i;
            state_q <= FS_REQ;
          end else begin
            tgt_q   <= ea_i;
            tgt_v_q <= 1'b1;
          end
        end
        FS_REQ:  if (rd_ready_i) state_q <= FS_WAIT;
        FS_WAIT: if (rd_data_valid_i) begin
          tgt_q   <= rd_data_i;
          tgt_v_q <= 1'b1;
          state_q <= FS_IDLE;
        end
        default: state_q <= FS_IDLE;
      endcase
    end
  end

  assign busy_o      = state_q != FS_IDLE;
  assign rd_valid_o  = state_q == FS_REQ;
  assign rd_addr_o   = addr_q;
  assign tgt_valid_o = tgt_v_q;
  assign tgt_o       = tgt_q;

  assert_rd_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_addr_o)));
  assert_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> busy_o);
  assert_tgt_after_data_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == FS_WAIT && rd_data_valid_i) |=> (tgt_valid_o && tgt_o == $past(rd_data_i)));
endmodule

// File: rtl/oa_operand_addr.sv
module oa_operand_addr
  import oa_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_valid_i,
  output logic         req_ready_o,
  input  logic [1:0]   op_i,
  input  logic [2:0]   dst_sel_i,
  input  logic [2:0]   idx_sel_i,
  input  logic [2:0]   base_sel_i,
  input  logic [15:0]  disp_i,
  input  logic [255:0] xreg_i,
  input  logic         base_we_i,
  input  logic [2:0]   base_wsel_i,
  input  logic [31:0]  base_wdata_i,
  output logic         res_valid_o,
  output logic [31:0]  ea_o,
  output logic         use_mem_o,
  output logic [2:0]   src_reg_o,
  output logic         rd_valid_o,
  input  logic         rd_ready_i,
  output logic [31:0]  rd_addr_o,
  input  logic         rd_data_valid_i,
  input  logic [31:0]  rd_data_i,
  output logic         tgt_valid_o,
  output logic [31:0]  tgt_o
);
  localparam int NREG = 8;
  localparam int AW   = 32;
  localparam int DW   = 16;
  localparam int SW   = $clog2(NREG);

  op_e           op;
  logic          accept, busy, is_opnd, is_lba, is_jump, reg_mode;
  logic          rf_we;
  logic [SW-1:0] rf_wsel;
  logic [AW-1:0] rf_wdata, base_val, ea;
  logic          res_v_q, mem_q;
  logic [AW-1:0] ea_q;
  logic [SW-1:0] src_q;

  assign op       = op_e'(op_i);
  assign accept   = req_valid_i && !busy;
  assign is_jump  = op == OP_JUMP;
  assign is_lba   = op == OP_LBA;
  assign is_opnd  = !is_jump && !is_lba;
  assign reg_mode = is_opnd && base_sel_i == '0;

  // address generation takes priority over the external write port
  always_comb begin
    rf_we    = base_we_i;
    rf_wsel  = base_wsel_i;
    rf_wdata = base_wdata_i;
    if (accept && is_lba) begin
      rf_we    = 1'b1;
      rf_wsel  = dst_sel_i;
      rf_wdata = ea;
    end
  end

  oa_base_rf #(.NREG(NREG), .AW(AW)) u_base_rf (
    .clk_i, .rst_ni,
    .we_i(rf_we), .wsel_i(rf_wsel), .wdata_i(rf_wdata),
    .rsel_i(base_sel_i), .rdata_o(base_val)
  );

  oa_addr_calc #(.NREG(NREG), .AW(AW), .DW(DW)) u_addr_calc (
    .base_val_i(base_val), .xreg_i, .idx_sel_i, .disp_i, .ea_o(ea)
  );

  oa_indirect_fetch #(.AW(AW)) u_fetch (
    .clk_i, .rst_ni,
    .start_i(accept && is_jump), .indirect_i(idx_sel_i != '0), .ea_i(ea),
    .busy_o(busy),
    .rd_valid_o, .rd_ready_i, .rd_addr_o, .rd_data_valid_i, .rd_data_i,
    .tgt_valid_o, .tgt_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_v_q <= 1'b0;
      mem_q   <= 1'b0;
      ea_q    <= '0;
      src_q   <= '0;
    end else begin
      res_v_q <= accept && !is_jump;
      if (accept && !is_jump) begin
        mem_q <= is_opnd && !reg_mode;
        ea_q  <= reg_mode ? '0 : ea;
        src_q <= idx_sel_i;
      end
    end
  end

  assign req_ready_o = !busy;
  assign res_valid_o = res_v_q;
  assign use_mem_o   = mem_q;
  assign ea_o        = ea_q;
  assign src_reg_o   = src_q;

  assert_excl_valid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({res_valid_o, tgt_valid_o}));
  assert_lba_no_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && is_lba) |=> (res_valid_o && !use_mem_o && !rd_valid_o));
  assert_res_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !$past(accept)) |-> 1'b0);
endmodule

// File: tb/oa_operand_addr_tb.sv
`timescale 1ns/1ps
module oa_operand_addr_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic         req_valid = 0, base_we = 0, rd_ready = 0, rd_dv = 0;
  logic [1:0]   op = 0;
  logic [2:0]   dsel = 0, xsel = 0, bsel = 0, bwsel = 0;
  logic [15:0]  disp = 0;
  logic [255:0] xregs;
  logic [31:0]  bwdata = 0, rd_data = 0;
  logic         req_ready, res_valid, use_mem, rd_valid, tgt_valid;
  logic [31:0]  ea, rd_addr, tgt;
  logic [2:0]   src_reg;
  int checks = 0, errors = 0;

  oa_operand_addr u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .op_i(op), .dst_sel_i(dsel), .idx_sel_i(xsel), .base_sel_i(bsel), .disp_i(disp),
    .xreg_i(xregs), .base_we_i(base_we), .base_wsel_i(bwsel), .base_wdata_i(bwdata),
    .res_valid_o(res_valid), .ea_o(ea), .use_mem_o(use_mem), .src_reg_o(src_reg),
    .rd_valid_o(rd_valid), .rd_ready_i(rd_ready), .rd_addr_o(rd_addr),
    .rd_data_valid_i(rd_dv), .rd_data_i(rd_data), .tgt_valid_o(tgt_valid), .tgt_o(tgt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_base(input logic [2:0] k, input logic [31:0] v);
    @(negedge clk); base_we = 1; bwsel = k; bwdata = v;
    @(negedge clk); base_we = 0;
  endtask

  // drives one request; returns at the negedge after the accepting edge
  task automatic issue(input logic [1:0] o, input logic [2:0] d, input logic [2:0] x,
                       input logic [2:0] b, input logic [15:0] dp);
    @(negedge clk); req_valid = 1; op = o; dsel = d; xsel = x; bsel = b; disp = dp;
    @(negedge clk); req_valid = 0;
  endtask

  task automatic t_reset;
    chk("R1 ready", req_ready, 1); chk("R1 res_valid", res_valid, 0);
    chk("R1 tgt_valid", tgt_valid, 0); chk("R1 rd_valid", rd_valid, 0);
  endtask

  task automatic t_base_index;
    issue(2'd0, 3'd0, 3'd2, 3'd3, 16'h0010);
    chk("R2 res_valid", res_valid, 1); chk("R2 use_mem", use_mem, 1);
    chk("R2 ea base+disp+idx", ea, 32'h1000_0030);
    @(negedge clk); chk("R10 res pulse", res_valid, 0);
    issue(2'd0, 3'd0, 3'd0, 3'd3, 16'h0010);
    chk("R3 no index when sel 0", ea, 32'h1000_0010);
    issue(2'd0, 3'd0, 3'd0, 3'd1, 16'hFFFF);
    chk("R2 zero-extended disp", ea, 32'h0001_0FFF);
    issue(2'd0, 3'd0, 3'd0, 3'd7, 16'h0020);
    chk("R2 wrap", ea, 32'h0000_0010);
    issue(2'd3, 3'd0, 3'd0, 3'd1, 16'h0002);
    chk("R2 op3 as operand ea", ea, 32'h0000_1002); chk("R2 op3 use_mem", use_mem, 1);
  endtask

  task automatic t_regmode;
    issue(2'd0, 3'd0, 3'd5, 3'd0, 16'h1234);
    chk("R4 res_valid", res_valid, 1); chk("R4 use_mem", use_mem, 0);
    chk("R4 src_reg", 32'(src_reg), 5); chk("R4 ea zero", ea, 0);
  endtask

  task automatic t_base0;
    wr_base(3'd0, 32'h0000_1234);
    issue(2'd2, 3'd6, 3'd0, 3'd0, 16'h0008);
    chk("R5 base0 adds zero", ea, 32'h0000_0008);
  endtask

  task automatic t_lba;
    issue(2'd2, 3'd4, 3'd0, 3'd3, 16'h0100);
    chk("R6 res_valid", res_valid, 1); chk("R6 ea", ea, 32'h1000_0100);
    chk("R6 use_mem", use_mem, 0); chk("R6 no read", rd_valid, 0);
    issue(2'd0, 3'd0, 3'd0, 3'd4, 16'h0004);
    chk("R6 base written", ea, 32'h1000_0104);
  endtask

  task automatic t_jump_direct;
    issue(2'd1, 3'd0, 3'd0, 3'd3, 16'h0020);
    chk("R7 tgt_valid", tgt_valid, 1); chk("R7 tgt", tgt, 32'h1000_0020);
    chk("R7 no read", rd_valid, 0); chk("R7 no res", res_valid, 0);
    @(negedge clk); chk("R9 tgt pulse", tgt_valid, 0);
  endtask

  task automatic t_jump_indirect;
    issue(2'd1, 3'd0, 3'd2, 3'd3, 16'h0008);
    chk("R8 rd_valid", rd_valid, 1); chk("R8 rd_addr", rd_addr, 32'h1000_0028);
    chk("R8 ready low", req_ready, 0); chk("R8 no early tgt", tgt_valid, 0);
    issue(2'd0, 3'd0, 3'd0, 3'd3, 16'h0000);
    chk("R8 ignored while busy", res_valid, 0);
    chk("R8 hold", rd_valid, 1); chk("R8 hold addr", rd_addr, 32'h1000_0028);
    rd_ready = 1;
    @(negedge clk); rd_ready = 0;
    chk("R8 released", rd_valid, 0); chk("R8 still busy", req_ready, 0);
    @(negedge clk); chk("R9 waiting", tgt_valid, 0);
    rd_dv = 1; rd_data = 32'hCAFE_0000;
    @(negedge clk); rd_dv = 0; rd_data = 0;
    chk("R9 tgt_valid", tgt_valid, 1); chk("R9 tgt data", tgt, 32'hCAFE_0000);
    chk("R9 ready again", req_ready, 1);
    @(negedge clk); chk("R9 tgt pulse", tgt_valid, 0);
  endtask

  initial begin
    for (int k = 0; k < 8; k++) xregs[k*32 +: 32] = 32'(k << 4);
    xregs[31:0] = 32'hDEAD_0000;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    wr_base(3'd3, 32'h1000_0000);
    wr_base(3'd1, 32'h0000_1000);
    wr_base(3'd7, 32'hFFFF_FFF0);
    t_base_index;
    t_regmode;
    t_base0;
    t_lba;
    t_jump_direct;
    t_jump_indirect;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule